// File: doc/BRIEF.md
# Buffered Elapsed Seconds Counter

This block keeps a free-running binary elapsed-time count made of a 12-bit fraction of a second and a 32-bit count of whole seconds. An internal prescaler derives one fractional tick from every `TICK_DIV` clock cycles; at full rate a tick is 1/4096 s. The host never touches the live count directly. It talks to a byte-wide register file in which a shadow copy of the six time bytes is refreshed from the live count on each tick, while the live count carries on independently.

Two handshake bits let software avoid torn accesses. The tracking bit in the control byte stops shadow refreshes when it is cleared, so the host can read a coherent snapshot or stage a new time. Setting it again pushes any staged bytes into the live count. A read-only refresh-pending flag in the status byte rises a fixed number of cycles before each refresh, so the host can see that a refresh is close. The control byte, a rate byte and three status flags are stored and read back unchanged; their alarm, periodic and waveform functions are not built here.

Top module: `elapsed_timer`

## Requirements
- R1: After reset all six time bytes read 00h, the control byte (0Ah) reads 80h (tracking on, counting off), and the rate byte (0Bh) and status byte (0Ch) read 00h.
- R2: Time byte map: 00h holds fraction bits 3..0 in bits 7:4, zeros in bits 3:1 and a stored wave-select bit in bit 0. 01h holds fraction bits 11..4. 02h..05h hold the seconds count, least significant byte at 02h.
- R3: While the run bit (bit 6 of 0Ah) is 1, the live count adds one on every tick. The fraction wraps from FFFh to 000h and carries into the seconds, and the seconds wrap from FFFFFFFFh to 0.
- R4: While the run bit is 0, the live count holds its value across ticks.
- R5: While the tracking bit (bit 7 of 0Ah) is 1, each tick copies the live count, including that tick's increment, into the shadow time bytes.
- R6: While the tracking bit is 0, the shadow time bytes change only through host writes. The live count keeps running, and the next refresh after tracking returns shows the advanced value.
- R7: Time bytes written while tracking is 0 are loaded into the live count in the cycle where a control write changes tracking from 0 to 1. If that cycle is also a tick, the load wins and the tick adds nothing.
- R8: A time-byte write while tracking is 1 lands in the shadow and reads back until the next refresh. If it falls in the refresh cycle, the refresh value wins. The wave-select bit is never overwritten by a refresh.
- R9: The refresh-pending flag (bit 6 of 0Ch) reads 1 for exactly `UIP_LEAD` cycles ending with the tick cycle, and only while tracking is 1. It reads 0 in every other cycle.
- R10: Bytes 0Ah and 0Bh read back as written. In 0Ch, bits 7, 1 and 0 are stored, bits 5:2 read 0 and the written bit 6 is ignored. Addresses 06h..09h and 0Dh..0Fh read 00h and ignore writes.
- R11: A tick occurs exactly once every `TICK_DIV` clock cycles, free-running from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register byte address |
| reg_we | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
A host write to a time byte and a shadow refresh can land on the same clock edge. A tracking re-enable that loads staged bytes can also coincide with a counting tick. The bench learns the tick phase from the first falling edge of the refresh-pending flag. It then places the byte write on the edge one full period after an observed refresh, and expects the refreshed value rather than the written one. It times the re-enable write to fall on a tick and checks that the loaded time shows no increment from that tick.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int FRAC_W    = 12;
  localparam int SEC_W     = 32;
  localparam int TIME_W    = FRAC_W + SEC_W;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int SEC_BYTES = SEC_W / DATA_W;
  localparam int FLAG_W    = 3;

  localparam logic [ADDR_W-1:0] A_FRAC_LO = 4'h0;
  localparam logic [ADDR_W-1:0] A_FRAC_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_SEC0    = 4'h2;
  localparam logic [ADDR_W-1:0] A_TIME_HI = 4'h5;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'hA;
  localparam logic [ADDR_W-1:0] A_RATE    = 4'hB;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'hC;

  localparam int B_TRACK = 7;
  localparam int B_RUN   = 6;
  localparam int B_PEND  = 6;

  localparam logic [DATA_W-1:0] CTRL_RST = 8'h80;

  typedef logic [TIME_W-1:0] time_t;
endpackage

// File: rtl/ets_prescaler.sv
module ets_prescaler #(
  parameter int TICK_DIV = 64,
  parameter int UIP_LEAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic lead_win
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST  = CW'(TICK_DIV - 1);
  localparam logic [CW-1:0] WSTRT = CW'(TICK_DIV - UIP_LEAD);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick     = (cnt_q == LAST);
    lead_win = (cnt_q >= WSTRT);
    cnt_d    = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ets_live_ctr.sv
module ets_live_ctr
  import ets_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  run,
  input  logic  load,
  input  time_t load_val,
  output time_t live_q,
  output time_t live_next
);
  logic step_en;

  always_comb begin
    step_en = tick && run;
    if (load)         live_next = load_val;
    else if (step_en) live_next = live_q + TIME_W'(1);
    else              live_next = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_q <= '0;
    else if (load || step_en)  live_q <= live_next;
  end
endmodule

// File: rtl/ets_regs.sv
module ets_regs
  import ets_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              lead_win,
  input  time_t             live_next,
  output logic [DATA_W-1:0] rdata,
  output logic              track,
  output logic              run,
  output logic              load,
  output logic              pend,
  output time_t             shadow_q
);
  time_t             shadow_d;
  logic              wsel_q, wsel_d;
  logic              dirty_q, dirty_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rate_q, rate_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic              wr_time, refresh;

  always_comb begin
    track   = ctrl_q[B_TRACK];
    run     = ctrl_q[B_RUN];
    pend    = track && lead_win;
    wr_time = we && (addr <= A_TIME_HI);
    refresh = tick && track;
    load    = we && (addr == A_CTRL) && wdata[B_TRACK] && !track && dirty_q;

    shadow_d = shadow_q;
    if (refresh) begin
      shadow_d = live_next;
    end else if (wr_time) begin
      if (addr == A_FRAC_LO)      shadow_d[3:0] = wdata[7:4];
      else if (addr == A_FRAC_HI) shadow_d[FRAC_W-1:4] = wdata;
      for (int b = 0; b < SEC_BYTES; b++)
        if (addr == A_SEC0 + ADDR_W'(b)) shadow_d[FRAC_W + DATA_W*b +: DATA_W] = wdata;
    end

    wsel_d = (we && addr == A_FRAC_LO) ? wdata[0] : wsel_q;
    ctrl_d = (we && addr == A_CTRL) ? wdata : ctrl_q;
    rate_d = (we && addr == A_RATE) ? wdata : rate_q;
    flag_d = (we && addr == A_STAT) ? {wdata[7], wdata[1:0]} : flag_q;

    if (load)                  dirty_d = 1'b0;
    else if (wr_time && !track) dirty_d = 1'b1;
    else                       dirty_d = dirty_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FRAC_LO: rdata = {shadow_q[3:0], 3'b000, wsel_q};
      A_FRAC_HI: rdata = shadow_q[FRAC_W-1:4];
      A_CTRL:    rdata = ctrl_q;
      A_RATE:    rdata = rate_q;
      A_STAT:    rdata = {flag_q[2], pend, 4'b0000, flag_q[1:0]};
      default: begin
        for (int b = 0; b < SEC_BYTES; b++)
          if (addr == A_SEC0 + ADDR_W'(b)) rdata = shadow_q[FRAC_W + DATA_W*b +: DATA_W];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      wsel_q   <= 1'b0;
      dirty_q  <= 1'b0;
      ctrl_q   <= CTRL_RST;
      rate_q   <= '0;
      flag_q   <= '0;
    end else begin
      shadow_q <= shadow_d;
      wsel_q   <= wsel_d;
      dirty_q  <= dirty_d;
      ctrl_q   <= ctrl_d;
      rate_q   <= rate_d;
      flag_q   <= flag_d;
    end
  end
endmodule

// File: rtl/elapsed_timer.sv
module elapsed_timer
  import ets_pkg::*;
#(
  parameter int TICK_DIV = 64,
  parameter int UIP_LEAD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] rst_sync;
  logic       rst_s;
  logic       tick, lead_win, track, run, load, pend;
  time_t      live_q, live_next, shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  ets_prescaler #(.TICK_DIV(TICK_DIV), .UIP_LEAD(UIP_LEAD)) u_pre (
    .clk(clk), .rst_n(rst_s), .tick(tick), .lead_win(lead_win)
  );

  ets_live_ctr u_live (
    .clk(clk), .rst_n(rst_s), .tick(tick), .run(run), .load(load),
    .load_val(shadow_q), .live_q(live_q), .live_next(live_next)
  );

  ets_regs u_regs (
    .clk(clk), .rst_n(rst_s), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .tick(tick), .lead_win(lead_win), .live_next(live_next), .rdata(reg_rdata),
    .track(track), .run(run), .load(load), .pend(pend), .shadow_q(shadow_q)
  );
endmodule

// File: rtl/ets_checker.sv
module ets_checker
  import ets_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              pend,
  input logic              track,
  input logic              run,
  input logic              load,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input time_t             live,
  input time_t             shadow
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !load) |=> (live == $past(live) + TIME_W'(1))); // R3

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(live)); // R4

  AST_REFRESH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && track) |=> (shadow == live)); // R5

  AST_FROZEN_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!track && !(we && addr <= A_TIME_HI)) |=> $stable(shadow)); // R6

  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (live == $past(shadow))); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !tick && !(we && addr == A_CTRL)) |=> pend); // R9

  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !pend); // R9
endmodule

bind elapsed_timer ets_checker u_chk (
  .clk(clk), .rst_n(rst_s), .tick(tick), .pend(pend), .track(track), .run(run),
  .load(load), .we(reg_we), .addr(reg_addr), .live(live_q), .shadow(shadow_q)
);

// File: tb/elapsed_timer_test.sv
module elapsed_timer_test;
  localparam int D    = 64;
  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  elapsed_timer #(.TICK_DIV(D), .UIP_LEAD(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct { logic [3:0] a; logic [7:0] e; string req; } item_t;
  item_t q[$];

  int total = 0, bad = 0, cyc = 0, last_w = 0, ph = 0;
  logic [43:0] ref_val;
  int  ref_cyc = 0;
  bit  ref_run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      check($sformatf("%s addr %0h", it.req, it.a), reg_rdata, it.e);
    end
  end

  task automatic expect_rd(logic [3:0] a, logic [7:0] e, string req);
    @(negedge clk);
    reg_addr = a;
    q.push_back('{a, e, req});
    #2;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    last_w = cyc;
  endtask

  function automatic int ticks_in(int a, int b);
    return ((b - ph + D * 1000) / D) - ((a - ph + D * 1000) / D);
  endfunction

  task automatic advance(int to);
    if (ref_run) ref_val = ref_val + 44'(ticks_in(ref_cyc, to));
    ref_cyc = to;
  endtask

  function automatic logic [7:0] byte_of(logic [43:0] v, int i);
    if (i == 0) return {v[3:0], 3'b000, 1'b1};
    if (i == 1) return v[11:4];
    return v[12 + 8 * (i - 2) +: 8];
  endfunction

  task automatic expect_time(logic [43:0] v, string req);
    for (int i = 0; i < 6; i++) expect_rd(4'(i), byte_of(v, i), req);
  endtask

  task automatic wait_falls(int n, output int p, output int hi_len);
    int cnt = 0, run_len = 0;
    bit prev = 0;
    @(negedge clk);
    reg_addr = 4'hC;
    hi_len = 0;
    while (cnt < n) begin
      @(negedge clk);
      #1;
      if (reg_rdata[6]) run_len++;
      else begin
        if (prev) begin cnt++; hi_len = run_len; end
        run_len = 0;
      end
      prev = reg_rdata[6];
    end
    p = cyc;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int p, hl, w;
    bit seen;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) expect_rd(4'(i), 8'h00, "R1");
    expect_rd(4'hA, 8'h80, "R1");
    expect_rd(4'hB, 8'h00, "R1");
    expect_rd(4'hC, 8'h00, "R1");

    // R11 R9 phase and window length; R4 halted count stays zero
    wait_falls(1, p, hl);
    ph = p % D;
    check("R9 window length", hl, LEAD);
    wait_falls(1, w, hl);
    check("R11 tick period", w - p, D);
    expect_rd(4'h2, 8'h00, "R4");

    // R2 R6 staging with tracking off
    wr(4'hA, 8'h00);
    ref_val = {32'h1234FFFF, 12'hFFE};
    wr(4'h0, 8'hE1); wr(4'h1, 8'hFF); wr(4'h2, 8'hFF);
    wr(4'h3, 8'hFF); wr(4'h4, 8'h34); wr(4'h5, 8'h12);
    expect_time(ref_val, "R2");
    repeat (2 * D) @(negedge clk);
    expect_rd(4'h0, 8'hE1, "R6");
    expect_rd(4'h5, 8'h12, "R6");
    reg_addr = 4'hC;
    seen = 0;
    for (int k = 0; k < D + 2; k++) begin
      @(negedge clk); #1;
      if (reg_rdata[6]) seen = 1;
    end
    check("R9 flag low while not tracking", seen, 0);

    // R7 R3 R5 load and rollovers of fraction and seconds
    wr(4'hA, 8'hC0);
    ref_cyc = last_w; ref_run = 1;
    wait_falls(5, p, hl);
    advance(p);
    wr(4'hA, 8'h40);
    expect_time(ref_val, "R3 R5 R7");

    // R6 live keeps running while frozen
    repeat (3 * D) @(negedge clk);
    wr(4'hA, 8'hC0);
    wait_falls(1, p, hl);
    advance(p);
    wr(4'hA, 8'h40);
    expect_time(ref_val, "R5 R6");

    // R4 run bit off holds the count
    wr(4'hA, 8'h80);
    advance(last_w);
    ref_run = 0;
    wait_falls(3, p, hl);
    advance(p);
    wr(4'hA, 8'h00);
    expect_time(ref_val, "R4");

    // R8 host write while tracking, and collision with refresh
    wr(4'hA, 8'hC0);
    advance(last_w);
    ref_run = 1;
    wait_falls(1, p, hl);
    advance(p);
    wr(4'h5, 8'hA5);
    expect_rd(4'h5, 8'hA5, "R8");
    while (cyc != p + D - 1) @(negedge clk);
    advance(p + D);
    reg_we = 1'b1; reg_addr = 4'h2; reg_wdata = ~byte_of(ref_val, 2);
    @(negedge clk);
    reg_we = 1'b0;
    wr(4'hA, 8'h40);
    expect_rd(4'h2, byte_of(ref_val, 2), "R8 collision");
    expect_rd(4'h5, byte_of(ref_val, 5), "R8");
    expect_rd(4'h0, byte_of(ref_val, 0), "R8 wave-select kept");

    // R10 stored bytes and ignored addresses
    wr(4'hB, 8'h5A);
    expect_rd(4'hB, 8'h5A, "R10");
    wr(4'hC, 8'hFF);
    expect_rd(4'hC, 8'h83, "R10");
    wr(4'h6, 8'hFF);
    expect_rd(4'h6, 8'h00, "R10");
    wr(4'hE, 8'hFF);
    expect_rd(4'hE, 8'h00, "R10");
    expect_rd(4'hA, 8'h40, "R10");

    // R7 load on a tick edge, R3 seconds wrap at 32 bits
    wr(4'h0, 8'hC1); wr(4'h1, 8'hFF); wr(4'h2, 8'hFF);
    wr(4'h3, 8'hFF); wr(4'h4, 8'hFF); wr(4'h5, 8'hFF);
    @(negedge clk);
    while (((cyc + 1 - ph) % D) != 0) @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'hA; reg_wdata = 8'hC0;
    @(negedge clk);
    reg_we = 1'b0;
    w = cyc;
    check("R7 load aligned to tick", (w - ph) % D, 0);
    ref_val = {32'hFFFFFFFF, 12'hFFC};
    ref_cyc = w; ref_run = 1;
    wait_falls(6, p, hl);
    advance(p);
    wr(4'hA, 8'h40);
    expect_time(ref_val, "R3 R7 precedence");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule